// File: doc/BRIEF.md
# Dual PLL Reprogramming Sequencer

This block walks a video controller's two clock synthesizers (the pixel-clock PLL and the loop-clock PLL) through a complete retune without software involvement. A single start pulse captures a pixel-PLL divider triple, a loop-clock post divider and a colour-depth code. The block then drives a one-transaction-at-a-time indexed register port. It stops both oscillators, programs the pixel PLL and waits for its lock, then programs the loop PLL with depth-dependent constants and waits for that lock too.

The sub-registers of each PLL (divider bytes and status) are reached through one shared pointer register, so each burst of data writes is preceded by a pointer write. Every lock wait has a cycle budget supplied at the port. When the budget runs out, the block stops and holds an error flag until it is started again. A successful pass ends with a one-cycle done pulse.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy_o, done_o, error_o, reg_wr_o and reg_rd_o are 0 and clk_src_sel_o is 2'b00.
- R2: After a start, the first four writes are, in order: index 0x1A data 0x75, index 0x2C data 0x2A, index 0x2F data 0x00, index 0x2D data 0x00. clk_src_sel_o is 2'b00 during these writes (it is cleared on start). After the fourth write it becomes 2'b11 and stays so until the next start.
- R3: The pixel PLL is then programmed by index 0x2C data 0x00, followed by three writes to index 0x2D: {2'b11, N[5:0]}, M, and P unchanged.
- R4: A lock poll writes index 0x2C data 0x3F, then reads the PLL's data index (0x2D for pixel, 0x2F for loop) repeatedly. The poll advances only on a completed read whose bit 6 is 1.
- R5: The loop divider write, index 0x39 data {4'h3, 1'b0, Q[2:0]}, comes only after the pixel PLL lock read.
- R6: The loop PLL is programmed by index 0x2C data 0x00, then three writes to index 0x2F: N then M chosen by depth code, then {4'hF, low nibble input}. The N/M pairs are: code 0 = 0xE1,0x3D; code 1 = 0xF1,0x3D; code 2 = 0xF9,0xBE; code 3 = 0xF9,0x3D. A lock poll on 0x2F follows.
- R7: Depth codes 4 to 7 give the code-0 constants 0xE1,0x3D.
- R8: A write strobe stays high with its index and data unchanged until reg_ready_i is seen high. reg_wr_o and reg_rd_o are never high together, and a transaction completes on each clock edge where a strobe and reg_ready_i are both high.
- R9: If a poll has not locked after timeout_i cycles, the poll ends after exactly timeout_i+1 cycles with reg_rd_o high. error_o then rises, busy_o falls and done_o stays 0. error_o holds until the next start.
- R10: After the loop PLL lock read, done_o is high for exactly one cycle and busy_o falls in that same cycle.
- R11: A start while busy_o is high is ignored. The values applied at the accepted start are used for the whole pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| pix_n_i | input | 8 | Pixel PLL N (upper two bits forced to 11) |
| pix_m_i | input | 8 | Pixel PLL M |
| pix_p_i | input | 8 | Pixel PLL P, including its enable bit |
| loop_q_i | input | 3 | Loop-clock Q divider |
| depth_i | input | 3 | Colour-depth code |
| loop_p_lo_i | input | 4 | Low nibble of the loop PLL P byte |
| timeout_i | input | TMO_W | Lock-poll budget in cycles |
| reg_idx_o | output | 8 | Register index |
| reg_wdata_o | output | 8 | Write data |
| reg_wr_o | output | 1 | Write strobe |
| reg_rd_o | output | 1 | Read strobe |
| reg_rdata_i | input | 8 | Read data |
| reg_ready_i | input | 1 | Transaction completes this cycle |
| clk_src_sel_o | output | 2 | PLL select field |
| busy_o | output | 1 | Sequence running |
| done_o | output | 1 | One-cycle success pulse |
| error_o | output | 1 | Lock timeout flag |

## Verification
A step counter that slips shows at once as a write with the wrong index or data, or out of place in the log of port transactions. That log is compared byte for byte with a list computed per pass from the captured inputs. A wrong poll decision shows within one transaction, as reads continuing after a locked value or a divider write before the lock read. A faulty timeout counter shows as a count of read cycles different from timeout_i+1 in the forced-failure pass. A bad done or error state shows as a pulse count other than one, or a flag that drops before the next start.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_ERR} state_e;
    typedef enum logic [1:0] {OP_WR, OP_RD, OP_SEL} op_e;

    localparam int unsigned STEP_W    = 5;
    localparam int unsigned SEL_STEP  = 4;
    localparam int unsigned PIX_POLL  = 10;
    localparam int unsigned LAST_STEP = 17;
    localparam int unsigned LOCK_BIT  = 6;

    localparam logic [7:0] IX_CLKSRC  = 8'h1A;
    localparam logic [7:0] IX_PTR     = 8'h2C;
    localparam logic [7:0] IX_PIXDAT  = 8'h2D;
    localparam logic [7:0] IX_LOOPDAT = 8'h2F;
    localparam logic [7:0] IX_QDIV    = 8'h39;
    localparam logic [7:0] PTR_P      = 8'h2A;
    localparam logic [7:0] PTR_N      = 8'h00;
    localparam logic [7:0] PTR_STAT   = 8'h3F;
    localparam logic [7:0] CLKSRC_VAL = 8'h75;

    typedef struct packed {
        logic [7:0] n;
        logic [7:0] m;
        logic [7:0] p;
        logic [2:0] q;
        logic [2:0] depth;
        logic [3:0] lp_lo;
    } cfg_t;

    // loop PLL {N, M} for a colour-depth code; unknown codes fall back to 8 bpp
    function automatic logic [15:0] loop_nm(input logic [2:0] depth);
        case (depth)
            3'd1:    loop_nm = {8'hF1, 8'h3D};
            3'd2:    loop_nm = {8'hF9, 8'hBE};
            3'd3:    loop_nm = {8'hF9, 8'h3D};
            default: loop_nm = {8'hE1, 8'h3D};
        endcase
    endfunction
endpackage

// File: rtl/pll_step_decode.sv
module pll_step_decode
    import pll_reprog_pkg::*;
(
    input  logic [STEP_W-1:0] step_i,
    input  cfg_t              cfg_i,
    output op_e               op_o,
    output logic [7:0]        idx_o,
    output logic [7:0]        data_o
);
    logic [15:0] lnm;
    assign lnm = loop_nm(cfg_i.depth);

    always_comb begin
        op_o   = OP_WR;
        idx_o  = IX_PTR;
        data_o = 8'h00;
        case (step_i)
            5'd0:  begin idx_o = IX_CLKSRC;  data_o = CLKSRC_VAL; end
            5'd1:  begin idx_o = IX_PTR;     data_o = PTR_P; end
            5'd2:  begin idx_o = IX_LOOPDAT; data_o = 8'h00; end
            5'd3:  begin idx_o = IX_PIXDAT;  data_o = 8'h00; end
            5'd4:  begin op_o  = OP_SEL; end
            5'd5:  begin idx_o = IX_PTR;     data_o = PTR_N; end
            5'd6:  begin idx_o = IX_PIXDAT;  data_o = {2'b11, cfg_i.n[5:0]}; end
            5'd7:  begin idx_o = IX_PIXDAT;  data_o = cfg_i.m; end
            5'd8:  begin idx_o = IX_PIXDAT;  data_o = cfg_i.p; end
            5'd9:  begin idx_o = IX_PTR;     data_o = PTR_STAT; end
            5'd10: begin op_o  = OP_RD;      idx_o  = IX_PIXDAT; end
            5'd11: begin idx_o = IX_QDIV;    data_o = {4'h3, 1'b0, cfg_i.q}; end
            5'd12: begin idx_o = IX_PTR;     data_o = PTR_N; end
            5'd13: begin idx_o = IX_LOOPDAT; data_o = {2'b11, lnm[13:8]}; end
            5'd14: begin idx_o = IX_LOOPDAT; data_o = lnm[7:0]; end
            5'd15: begin idx_o = IX_LOOPDAT; data_o = {4'hF, cfg_i.lp_lo}; end
            5'd16: begin idx_o = IX_PTR;     data_o = PTR_STAT; end
            5'd17: begin op_o  = OP_RD;      idx_o  = IX_LOOPDAT; end
            default: begin op_o = OP_SEL; end
        endcase
    end
endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (cnt_q != {TMO_W{1'b1}})
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = run_i && (cnt_q >= limit_i);

    // R9: the counter is idle whenever no poll is running
    a_r9_cnt_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> cnt_q == '0);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_reprog_pkg::*;
#(
    parameter int unsigned TMO_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [7:0]       pix_n_i,
    input  logic [7:0]       pix_m_i,
    input  logic [7:0]       pix_p_i,
    input  logic [2:0]       loop_q_i,
    input  logic [2:0]       depth_i,
    input  logic [3:0]       loop_p_lo_i,
    input  logic [TMO_W-1:0] timeout_i,
    output logic [7:0]       reg_idx_o,
    output logic [7:0]       reg_wdata_o,
    output logic             reg_wr_o,
    output logic             reg_rd_o,
    input  logic [7:0]       reg_rdata_i,
    input  logic             reg_ready_i,
    output logic [1:0]       clk_src_sel_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             error_o
);
    typedef struct packed {
        state_e            st;
        logic [STEP_W-1:0] step;
        logic [1:0]        sel;
        logic              done;
        logic              err;
        cfg_t              cfg;
    } seq_t;

    seq_t s_d, s_q;
    op_e        op;
    logic [7:0] idx, wdata;
    logic       polling, expired, locked;

    pll_step_decode i_decode (
        .step_i (s_q.step),
        .cfg_i  (s_q.cfg),
        .op_o   (op),
        .idx_o  (idx),
        .data_o (wdata)
    );

    assign polling = (s_q.st == ST_RUN) && (op == OP_RD);

    poll_timer #(.TMO_W(TMO_W)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (polling),
        .limit_i   (timeout_i),
        .expired_o (expired)
    );

    assign locked = reg_ready_i && reg_rdata_i[LOCK_BIT];

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        case (s_q.st)
            ST_RUN: begin
                if (op == OP_SEL) begin
                    s_d.sel  = 2'b11;
                    s_d.step = s_q.step + 1'b1;
                end else if (op == OP_WR) begin
                    if (reg_ready_i) s_d.step = s_q.step + 1'b1;
                end else if (locked) begin
                    if (s_q.step == STEP_W'(LAST_STEP)) begin
                        s_d.st   = ST_IDLE;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.step = s_q.step + 1'b1;
                    end
                end else if (expired) begin
                    s_d.st  = ST_ERR;
                    s_d.err = 1'b1;
                end
            end
            default: begin
                if (start_i) begin
                    s_d.st   = ST_RUN;
                    s_d.step = '0;
                    s_d.sel  = 2'b00;
                    s_d.err  = 1'b0;
                    s_d.cfg  = '{n: pix_n_i, m: pix_m_i, p: pix_p_i, q: loop_q_i,
                                 depth: depth_i, lp_lo: loop_p_lo_i};
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy_o        = (s_q.st == ST_RUN);
    assign reg_wr_o      = busy_o && (op == OP_WR);
    assign reg_rd_o      = polling;
    assign reg_idx_o     = busy_o ? idx : 8'h00;
    assign reg_wdata_o   = reg_wr_o ? wdata : 8'h00;
    assign clk_src_sel_o = s_q.sel;
    assign done_o        = s_q.done;
    assign error_o       = s_q.err;

    // R8: a pending write keeps its strobe, index and data
    a_r8_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_o && !reg_ready_i) |=> reg_wr_o && $stable(reg_idx_o) && $stable(reg_wdata_o));
    // R8: one transaction kind at a time
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr_o && reg_rd_o));
    // R10: done is a single-cycle pulse and never coincides with busy
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o && !error_o);
    // R9: error holds until a start arrives
    a_r9_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (error_o && !start_i) |=> error_o);
    // R11: a start while busy does not restart the pass
    a_r11_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && s_q.step != '0 && op == OP_WR && !reg_ready_i) |=> s_q.step != '0);
    // R2: select field only rises on the select step
    a_r2_sel_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(clk_src_sel_o[0]) |-> $past(s_q.step) == STEP_W'(SEL_STEP));
endmodule

// File: tb/test_pll_reprog_seq.sv
module test_pll_reprog_seq;
    localparam int CLK_PERIOD = 10;
    localparam int TMO_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [7:0] pix_n_i = '0, pix_m_i = '0, pix_p_i = '0;
    logic [2:0] loop_q_i = '0, depth_i = '0;
    logic [3:0] loop_p_lo_i = '0;
    logic [TMO_W-1:0] timeout_i = 16'd200;
    logic [7:0] reg_idx_o, reg_wdata_o, reg_rdata_i = '0;
    logic reg_wr_o, reg_rd_o, reg_ready_i = 1'b0;
    logic [1:0] clk_src_sel_o;
    logic busy_o, done_o, error_o;

    pll_reprog_seq #(.TMO_W(TMO_W)) i_pll_reprog_seq (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;
    // responder log
    logic [7:0] w_idx [32];
    logic [7:0] w_dat [32];
    logic [1:0] w_sel [32];
    int w_rb [32];
    int wcnt, pix_rd, loop_rd, bad_rd_idx, rd_cyc, hold_viol;
    int lock_pix, lock_loop;
    logic pend_wr;
    logic [7:0] pend_idx, pend_dat;
    int cycles = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // register port model: random ready, lock after a set number of reads
    always @(negedge clk) begin
        logic rdy;
        rdy = ($urandom % 2) == 0;
        if (pend_wr && !(reg_wr_o && reg_idx_o == pend_idx && reg_wdata_o == pend_dat))
            hold_viol++;
        pend_wr = reg_wr_o && !rdy;
        pend_idx = reg_idx_o;
        pend_dat = reg_wdata_o;
        if (reg_rd_o) rd_cyc++;
        reg_rdata_i = 8'($urandom) & 8'hBF;
        if (reg_wr_o && rdy && wcnt < 32) begin
            w_idx[wcnt] = reg_idx_o;
            w_dat[wcnt] = reg_wdata_o;
            w_sel[wcnt] = clk_src_sel_o;
            w_rb[wcnt]  = pix_rd + loop_rd;
            wcnt++;
        end
        if (reg_rd_o && rdy) begin
            if (reg_idx_o == 8'h2D) begin
                if (pix_rd == lock_pix) reg_rdata_i[6] = 1'b1;
                pix_rd++;
            end else if (reg_idx_o == 8'h2F) begin
                if (loop_rd == lock_loop) reg_rdata_i[6] = 1'b1;
                loop_rd++;
            end else bad_rd_idx++;
        end
        reg_ready_i = rdy;
    end

    function automatic logic [15:0] exp_loop(input logic [2:0] d);
        case (d)
            3'd1: return 16'hF13D;
            3'd2: return 16'hF9BE;
            3'd3: return 16'hF93D;
            default: return 16'hE13D;
        endcase
    endfunction

    task automatic run_pass(input logic [7:0] n, m, p, input logic [2:0] q, d,
                            input logic [3:0] lo, input int lp, ll, input bit poke);
        logic [7:0] ei [15];
        logic [7:0] ed [15];
        logic [15:0] lnm;
        int dones = 0, k = 0;
        lnm = exp_loop(d);
        ei = '{8'h1A, 8'h2C, 8'h2F, 8'h2D, 8'h2C, 8'h2D, 8'h2D, 8'h2D, 8'h2C,
               8'h39, 8'h2C, 8'h2F, 8'h2F, 8'h2F, 8'h2C};
        ed = '{8'h75, 8'h2A, 8'h00, 8'h00, 8'h00, {2'b11, n[5:0]}, m, p, 8'h3F,
               {5'b00110, q}, 8'h00, {2'b11, lnm[13:8]}, lnm[7:0], {4'hF, lo}, 8'h3F};
        @(negedge clk);
        wcnt = 0; pix_rd = 0; loop_rd = 0; bad_rd_idx = 0; hold_viol = 0;
        lock_pix = lp; lock_loop = ll;
        pix_n_i = n; pix_m_i = m; pix_p_i = p; loop_q_i = q; depth_i = d; loop_p_lo_i = lo;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        pix_n_i = ~n; pix_m_i = ~m; depth_i = d + 3'd1; loop_q_i = ~q; // R11 captured values
        do begin
            @(negedge clk);
            k++;
            if (poke && k == 7) start_i = 1'b1;   // R11 start while busy
            else start_i = 1'b0;
            if (done_o) dones++;
        end while (busy_o && k < 5000);
        start_i = 1'b0;
        chk(wcnt == 15, "R2", "write count", wcnt, 15);
        for (int i = 0; i < 15 && i < wcnt; i++) begin
            chk(w_idx[i] == ei[i] && w_dat[i] == ed[i], i < 4 ? "R2" : i < 9 ? "R3" :
                i == 9 ? "R5" : (d > 3 ? "R7" : "R6"), "write idx/data",
                {w_idx[i], w_dat[i]}, {ei[i], ed[i]});
            chk(w_sel[i] == (i < 4 ? 2'b00 : 2'b11), "R2", "select field at write",
                w_sel[i], i < 4 ? 0 : 3);
            chk(w_rb[i] == (i < 9 ? 0 : lp + 1) && (i < 9 || w_rb[i] != 0) , "R5",
                "reads before write", w_rb[i], i < 9 ? 0 : lp + 1);
        end
        chk(pix_rd == lp + 1 && loop_rd == ll + 1 && bad_rd_idx == 0, "R4",
            "poll reads pix/loop", pix_rd * 256 + loop_rd, (lp + 1) * 256 + ll + 1);
        chk(dones == 1 && !error_o, "R10", "done pulses", dones, 1);
        chk(hold_viol == 0, "R8", "write hold violations", hold_viol, 0);
        chk(clk_src_sel_o == 2'b11, "R2", "select held after pass", clk_src_sel_o, 3);
    endtask

    initial begin
        void'($urandom(32'd1234));
        lock_pix = 0; lock_loop = 0; wcnt = 0; pend_wr = 0;
        rd_cyc = 0; hold_viol = 0; pix_rd = 0; loop_rd = 0; bad_rd_idx = 0;
        repeat (3) @(negedge clk);
        chk(!busy_o && !done_o && !error_o && !reg_wr_o && !reg_rd_o && clk_src_sel_o == 2'b00,
            "R1", "reset outputs", {busy_o, done_o, error_o, reg_wr_o, reg_rd_o}, 0);
        rst_n = 1'b1;
        // directed: every depth code, incl. the invalid ones (R6, R7)
        for (int d = 0; d < 8; d++)
            run_pass(8'h12, 8'h34, 8'hB6, 3'd5, 3'(d), 4'h2, 0, 0, 1'b0);
        // R11: start pulse during a pass
        run_pass(8'h3F, 8'hC5, 8'hF0, 3'd7, 3'd2, 4'hA, 2, 1, 1'b1);
        // random passes
        for (int r = 0; r < 20; r++)
            run_pass(8'($urandom), 8'($urandom), 8'($urandom), 3'($urandom), 3'($urandom),
                     4'($urandom), $urandom % 4, $urandom % 4, r % 5 == 0);
        // R9: pixel PLL never locks
        begin
            int ec = 0;
            timeout_i = 16'd20;
            @(negedge clk);
            lock_pix = 100000; lock_loop = 0; wcnt = 0; pix_rd = 0; loop_rd = 0;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            while (busy_o && ec < 2000) begin
                if (reg_idx_o != 8'h2D || !reg_rd_o) rd_cyc = 0;
                @(negedge clk);
                ec++;
            end
            chk(rd_cyc == 21, "R9", "read cycles before timeout", rd_cyc, 21);
            chk(error_o && !done_o && !busy_o, "R9", "error raised",
                {error_o, done_o, busy_o}, 4);
            repeat (6) @(negedge clk);
            chk(error_o && !reg_rd_o && !reg_wr_o, "R9", "error held", error_o, 1);
            timeout_i = 16'd200;
            run_pass(8'h01, 8'h02, 8'h03, 3'd1, 3'd1, 4'h1, 1, 1, 1'b0);
            chk(!error_o, "R9", "error cleared by start", error_o, 0);
        end
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule